// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a one-way word queue between two clock domains. Words enter through a write port clocked by `wclk` and leave through a read port clocked by `rclk`. The two clocks may be unrelated. Each port moves a word only on a rising edge of its own clock, and only while its active-low select is low and its active-high enable is high. Storage is a register array of 2^ADDR_W words. The write and read pointers are one bit wider than the address. Each pointer crosses to the other domain as a gray code through a two-flop synchroniser.

The read timing is fixed once per reset. The first read-clock edge after reset is released samples `mode_i`, and that choice is then held.
- **Standard timing** (`mode_i` high): a read request pops one word into the output register. `rd_flag` means "not empty".
- **Fall-through timing** (`mode_i` low): the oldest word is loaded into the output register without a request. `rd_flag` rises on the same edge that loads the word.

Capacity is the same in both modes. In fall-through timing, the word shown on the output still occupies its memory slot until it is read.

There are two programmable threshold flags, both active low:
- `ae_n` goes low when the stored count is at or below `AE_OFS`. It is computed in the read domain.
- `af_n` goes low when the free count is at or below `AF_OFS`. It is computed in the write domain.

Because pointers pass through the synchronisers, a flag shows an operation made on the other side two to three cycles of its own clock later.

Read-side states:
- RD_ARM goes to RD_STD when `mode_i` is high and to RD_FW_EMPTY when it is low.
- RD_STD always stays in RD_STD.
- RD_FW_EMPTY goes to RD_FW_VALID when the memory is not empty, loading `mem[rptr]`.
- In RD_FW_VALID, a read with another word behind it stays in RD_FW_VALID and loads `mem[rptr+1]`. A read of the last word returns to RD_FW_EMPTY.

Write-side states:
- WR_ARM always goes to WR_RUN.
- WR_RUN always stays in WR_RUN.

Top module: `xclk_fifo`

## Requirements
- R1: A word is written only on a rising `wclk` edge with `wr_cs_n`=0 and `wr_en`=1, and read only on a rising `rclk` edge with `rd_cs_n`=0 and `rd_en`=1. Any other combination leaves the stored contents and all flags unchanged.
- R2: The first `rclk` edge after reset release samples `mode_i`: 1 selects standard timing and 0 selects fall-through timing. The mode then holds until the next reset. In standard timing, `dout` never changes without a read.
- R3: In standard timing, `rd_flag`=1 exactly when the stored count is above zero. A read taken on an edge places the oldest word on `dout` right after that edge.
- R4: In fall-through timing, the oldest word appears on `dout` with `rd_flag`=1 without any read request. `dout` and `rd_flag` hold until a read. A read shows the next word after that edge, or drops `rd_flag` to 0 if none is left.
- R5: `wr_flag`=1 exactly when the write side is running and at least one location is free. It is 0 when all 2^ADDR_W locations are used.
- R6: `ae_n`=0 exactly when the stored count is at or below `AE_OFS`. The stored count includes a word held on `dout` in fall-through timing.
- R7: `af_n`=0 exactly when the free count (2^ADDR_W minus the stored count) is at or below `AF_OFS`.
- R8: A write while full and a read while empty are ignored, and the pointers do not move. Words leave in the order they were written.
- R9: While reset is held, `rd_flag`=0, `wr_flag`=0, `ae_n`=0, `dout`=0, and `af_n`=1 when `AF_OFS` < 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low master reset for both domains |
| mode_i | input | 1 | Timing select, sampled after reset: 1 standard, 0 fall-through |
| wr_cs_n | input | 1 | Write port select, active low |
| wr_en | input | 1 | Write port enable, active high |
| din | input | W | Write data |
| wr_flag | output | 1 | Standard: not full; fall-through: input ready |
| af_n | output | 1 | Almost-full, low when free count <= AF_OFS (write clock) |
| rd_cs_n | input | 1 | Read port select, active low |
| rd_en | input | 1 | Read port enable, active high |
| dout | output | W | Read data register |
| rd_flag | output | 1 | Standard: not empty; fall-through: output ready |
| ae_n | output | 1 | Almost-empty, low when stored count <= AE_OFS (read clock) |

## Verification
A pointer that steps wrongly, or that moves on an ignored access, shows up as flags that disagree with the true count. This appears within about three cycles of the observing clock, once the crossing settles, and the bench checks at every fill level from empty to full. A wrong address choice in the fall-through prefetch, or a wrong pop decision, shows up as a wrong or repeated word on `dout` at the next read. A wrong mode capture shows up as the first word appearing, or failing to appear, before any read request.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
    typedef enum logic [1:0] {
        RD_ARM      = 2'd0,
        RD_STD      = 2'd1,
        RD_FW_EMPTY = 2'd2,
        RD_FW_VALID = 2'd3
    } rd_state_e;

    typedef enum logic {
        WR_ARM = 1'b0,
        WR_RUN = 1'b1
    } wr_state_e;
endpackage

// File: rtl/xclk_gray_sync.sv
module xclk_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_i,
    output logic [W-1:0] bin_o
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_i;
            stage2 <= stage1;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_g2b
        assign bin_o[i] = ^stage2[W-1:i];
    end
endmodule

// File: rtl/xclk_ram.sv
module xclk_ram #(
    parameter int ADDR_W = 4,
    parameter int W      = 36
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [W-1:0]      rdata_a,
    output logic [W-1:0]      rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/xclk_wr_ctrl.sv
module xclk_wr_ctrl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int AF_OFS = 2
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_cs_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rptr_sync,
    output logic [ADDR_W:0]   wgray,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic              wr_flag,
    output logic              af_n
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    wr_state_e        st, st_nxt;
    logic [PTR_W-1:0] wptr, wptr_nxt, used, free;
    logic             full, wr_req, wr_go;

    assign wr_req = !wr_cs_n && wr_en;
    assign full   = (wptr[ADDR_W] != rptr_sync[ADDR_W]) &&
                    (wptr[ADDR_W-1:0] == rptr_sync[ADDR_W-1:0]);
    assign used   = wptr - rptr_sync;
    assign free   = PTR_W'(DEPTH) - used;

    always_comb begin
        st_nxt = st;
        wr_go  = 1'b0;
        unique case (st)
            WR_ARM: st_nxt = WR_RUN;
            WR_RUN: wr_go  = wr_req && !full;
            default: st_nxt = WR_ARM;
        endcase
    end

    assign wptr_nxt = wptr + PTR_W'(wr_go);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) st <= WR_ARM;
        else        st <= st_nxt;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    always_comb begin
        mem_we    = wr_go;
        mem_waddr = wptr[ADDR_W-1:0];
        wr_flag   = (st == WR_RUN) && !full;
        af_n      = !(32'(free) <= AF_OFS);
    end

    // R8: a blocked write while full leaves the write pointer in place
    assert_no_overflow_R8: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && wr_req) |=> $stable(wptr));

    // R1: no pointer movement without select and enable
    assert_write_qualified_R1: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_req |=> $stable(wptr));

    // R7: a running, non-ready write side must already be almost full
    assert_full_implies_af_R7: assert property (@(posedge wclk) disable iff (!rst_n)
        ((st == WR_RUN) && !wr_flag) |-> !af_n);
endmodule

// File: rtl/xclk_rd_ctrl.sv
module xclk_rd_ctrl
    import xclk_fifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int W      = 36,
    parameter int AE_OFS = 2
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              rd_cs_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wptr_sync,
    input  logic [W-1:0]      rdata_a,
    input  logic [W-1:0]      rdata_b,
    output logic [ADDR_W-1:0] raddr_a,
    output logic [ADDR_W-1:0] raddr_b,
    output logic [ADDR_W:0]   rgray,
    output logic [W-1:0]      dout,
    output logic              rd_flag,
    output logic              ae_n
);
    localparam int PTR_W = ADDR_W + 1;

    rd_state_e        st, st_nxt;
    logic [PTR_W-1:0] rptr, rptr_inc, rptr_nxt, count;
    logic             empty, more, rd_req, pop, load, use_b;

    assign rd_req   = !rd_cs_n && rd_en;
    assign rptr_inc = rptr + PTR_W'(1);
    assign empty    = (rptr == wptr_sync);
    assign more     = (rptr_inc != wptr_sync);
    assign count    = wptr_sync - rptr;
    assign raddr_a  = rptr[ADDR_W-1:0];
    assign raddr_b  = rptr_inc[ADDR_W-1:0];

    always_comb begin
        st_nxt = st;
        pop    = 1'b0;
        load   = 1'b0;
        use_b  = 1'b0;
        unique case (st)
            RD_ARM: st_nxt = mode_i ? RD_STD : RD_FW_EMPTY;
            RD_STD: begin
                if (rd_req && !empty) begin
                    pop  = 1'b1;
                    load = 1'b1;
                end
            end
            RD_FW_EMPTY: begin
                if (!empty) begin
                    load   = 1'b1;
                    st_nxt = RD_FW_VALID;
                end
            end
            RD_FW_VALID: begin
                if (rd_req) begin
                    pop = 1'b1;
                    if (more) begin
                        load  = 1'b1;
                        use_b = 1'b1;
                    end else begin
                        st_nxt = RD_FW_EMPTY;
                    end
                end
            end
            default: st_nxt = RD_ARM;
        endcase
    end

    assign rptr_nxt = rptr + PTR_W'(pop);

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) st <= RD_ARM;
        else        st <= st_nxt;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
            dout  <= '0;
        end else begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (load) dout <= use_b ? rdata_b : rdata_a;
        end
    end

    always_comb begin
        unique case (st)
            RD_STD:      rd_flag = !empty;
            RD_FW_VALID: rd_flag = 1'b1;
            default:     rd_flag = 1'b0;
        endcase
        ae_n = !(32'(count) <= AE_OFS);
    end

    // R8: the read pointer never moves while the memory is empty
    assert_no_underflow_R8: assert property (@(posedge rclk) disable iff (!rst_n)
        empty |=> $stable(rptr));

    // R4: a presented word is held until it is read
    assert_fwft_hold_R4: assert property (@(posedge rclk) disable iff (!rst_n)
        ((st == RD_FW_VALID) && !rd_req) |=> ($stable(dout) && rd_flag));

    // R2: standard timing, once chosen, is kept
    assert_mode_locked_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        (st == RD_STD) |=> (st == RD_STD));

    // R2: the arm state is left for good after one cycle
    assert_arm_once_R2: assert property (@(posedge rclk) disable iff (!rst_n)
        (st != RD_ARM) |=> (st != RD_ARM));

    // R6: an empty standard-timing queue is almost empty
    assert_empty_ae_R6: assert property (@(posedge rclk) disable iff (!rst_n)
        ((st == RD_STD) && !rd_flag) |-> !ae_n);
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int ADDR_W = 4,
    parameter int W      = 36,
    parameter int AE_OFS = 2,
    parameter int AF_OFS = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         mode_i,
    input  logic         wr_cs_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    output logic         wr_flag,
    output logic         af_n,
    input  logic         rd_cs_n,
    input  logic         rd_en,
    output logic [W-1:0] dout,
    output logic         rd_flag,
    output logic         ae_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wgray, rgray, wptr_sync, rptr_sync;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, raddr_a, raddr_b;
    logic [W-1:0]      rdata_a, rdata_b;

    xclk_wr_ctrl #(.ADDR_W(ADDR_W), .AF_OFS(AF_OFS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wr_cs_n(wr_cs_n), .wr_en(wr_en),
        .rptr_sync(rptr_sync), .wgray(wgray), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .wr_flag(wr_flag), .af_n(af_n)
    );

    xclk_ram #(.ADDR_W(ADDR_W), .W(W)) u_ram (
        .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
        .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    xclk_gray_sync #(.W(PTR_W)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_i(wgray), .bin_o(wptr_sync)
    );

    xclk_gray_sync #(.W(PTR_W)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_i(rgray), .bin_o(rptr_sync)
    );

    xclk_rd_ctrl #(.ADDR_W(ADDR_W), .W(W), .AE_OFS(AE_OFS)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .mode_i(mode_i), .rd_cs_n(rd_cs_n),
        .rd_en(rd_en), .wptr_sync(wptr_sync), .rdata_a(rdata_a),
        .rdata_b(rdata_b), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rgray(rgray), .dout(dout), .rd_flag(rd_flag), .ae_n(ae_n)
    );
endmodule

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
    localparam int ADDR_W = 3;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int W      = 36;
    localparam int AE_OFS = 2;
    localparam int AF_OFS = 2;

    logic         wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, mode_i = 1'b1;
    logic         wr_cs_n = 1'b1, wr_en = 1'b0, rd_cs_n = 1'b1, rd_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         wr_flag, af_n, rd_flag, ae_n;

    int vectors = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic [W-1:0] last_exp;

    always #2 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    xclk_fifo #(.ADDR_W(ADDR_W), .W(W), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS)) u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .mode_i(mode_i),
        .wr_cs_n(wr_cs_n), .wr_en(wr_en), .din(din), .wr_flag(wr_flag),
        .af_n(af_n), .rd_cs_n(rd_cs_n), .rd_en(rd_en), .dout(dout),
        .rd_flag(rd_flag), .ae_n(ae_n)
    );

    function automatic logic [W-1:0] pat(int n, int i);
        return {4'(n + 1), 32'(i * 32'h01010101 + n * 32'h00009e37 + 32'h5a)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (10) @(negedge rclk);
        repeat (10) @(negedge wclk);
    endtask

    task automatic wr(input logic cs_n, input logic en, input logic [W-1:0] d);
        @(negedge wclk);
        wr_cs_n = cs_n; wr_en = en; din = d;
        @(negedge wclk);
        wr_cs_n = 1'b1; wr_en = 1'b0;
    endtask

    task automatic rd(input logic cs_n, input logic en);
        @(negedge rclk);
        rd_cs_n = cs_n; rd_en = en;
        @(negedge rclk);
        rd_cs_n = 1'b1; rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0;
        mode_i = m;
        repeat (3) @(negedge wclk);
        chk("R9 rd_flag in reset", 64'(rd_flag), 64'd0);
        chk("R9 wr_flag in reset", 64'(wr_flag), 64'd0);
        chk("R9 ae_n in reset", 64'(ae_n), 64'd0);
        chk("R9 af_n in reset", 64'(af_n), 64'd1);
        chk("R9 dout in reset", 64'(dout), 64'd0);
        @(negedge rclk);
        rst_n = 1'b1;
        last_exp = '0;
        settle();
    endtask

    task automatic flags(input int n, input string ctx);
        @(negedge rclk);
        chk({"R3/R4 rd_flag ", ctx}, 64'(rd_flag), 64'(n > 0));
        chk({"R6 ae_n ", ctx}, 64'(ae_n), 64'(!(n <= AE_OFS)));
        @(negedge wclk);
        chk({"R5 wr_flag ", ctx}, 64'(wr_flag), 64'(n < DEPTH));
        chk({"R7 af_n ", ctx}, 64'(af_n), 64'(!((DEPTH - n) <= AF_OFS)));
    endtask

    task automatic run_mode(input logic m);
        logic [W-1:0] one;
        do_reset(m);
        one = 36'h0_dead_beef;
        // R1: unqualified writes are ignored
        wr(1'b1, 1'b1, 36'h1_1111_1111);
        wr(1'b0, 1'b0, 36'h2_2222_2222);
        // R8: read on empty is ignored
        rd(1'b0, 1'b1);
        settle();
        flags(0, "R1 after unqualified writes");
        wr(1'b0, 1'b1, one);
        settle();
        // R1: unqualified reads are ignored
        rd(1'b1, 1'b1);
        rd(1'b0, 1'b0);
        settle();
        flags(1, "R1 after unqualified reads");
        if (m) begin
            chk("R2 std no fall-through", 64'(dout), 64'(last_exp));
            rd(1'b0, 1'b1);
            chk("R3 R8 single word", 64'(dout), 64'(one));
        end else begin
            chk("R4 R8 single word presented", 64'(dout), 64'(one));
            rd(1'b0, 1'b1);
        end
        last_exp = one;
        settle();
        flags(0, "after single word");

        for (int n = 0; n <= DEPTH; n++) begin
            for (int i = 0; i < n; i++) wr(1'b0, 1'b1, pat(n, i));
            if (n == DEPTH) begin
                // R8: writes while full are dropped
                wr(1'b0, 1'b1, 36'hf_ffff_0001);
                wr(1'b0, 1'b1, 36'hf_ffff_0002);
            end
            settle();
            flags(n, $sformatf("level %0d", n));
            @(negedge rclk);
            if (m) begin
                chk("R2 std dout holds without read", 64'(dout), 64'(last_exp));
                for (int i = 0; i < n; i++) begin
                    rd(1'b0, 1'b1);
                    chk($sformatf("R3 R8 std word %0d of %0d", i, n), 64'(dout), 64'(pat(n, i)));
                    last_exp = pat(n, i);
                end
            end else begin
                for (int i = 0; i < n; i++) begin
                    chk($sformatf("R4 R8 fwft word %0d of %0d", i, n), 64'(dout), 64'(pat(n, i)));
                    chk("R4 fwft rd_flag before read", 64'(rd_flag), 64'd1);
                    rd(1'b0, 1'b1);
                end
                if (n > 0) chk("R4 fwft rd_flag after last", 64'(rd_flag), 64'd0);
            end
            settle();
            flags(0, $sformatf("drained from %0d", n));
        end
    endtask

    initial begin
        run_mode(1'b1);
        run_mode(1'b0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    always @(posedge wclk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            fails++;
            vectors++;
            $display("FAIL watchdog R9 actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule